// File: doc/BRIEF.md
# Serial Controller Interrupt Identification

This block merges the interrupt causes of a byte-oriented serial controller into one request line and one identification byte that software reads. It watches five causes: receive line errors (overrun, parity, framing, break), receive data at the FIFO trigger level, a receive character timeout, transmit holding register empty, and a modem status change. Each cause passes through its own enable bit. The most urgent enabled cause is then encoded into the low nibble of the identification byte. Bit 0 of that nibble is low while anything is pending.

Line errors and the transmit-empty event arrive as one-cycle pulses and are held inside the block. Line errors stay held until the line status register is read. The transmit-empty cause is held in a two-state machine: **TXE_QUIET** (nothing owed) and **TXE_OWED** (interrupt owed). It moves QUIET→OWED on the *empty event* transition. It moves OWED→QUIET on the *acknowledge* transition, which happens on a holding-register write or on a read of the identification byte while that byte shows the transmit-empty code. The receive-level, timeout and modem causes are levels produced outside the block.

The interrupt output is qualified by a modem-control master enable. The FIFO mode is reflected in the top two bits of the identification byte.

Top module: `uart_int_ident`

## Requirements
- R1: After reset, `ident` reads 0x01, `irq` is low, and neither held cause (line error, transmit empty) is pending.
- R2: `ident[0]` is 0 while an enabled cause is pending and 1 otherwise. With nothing pending, `ident[3:0]` is 0x1. `ident[5:4]` is always 00.
- R3: The cause codes in `ident[3:0]` are: line error 0x6, receive data at trigger 0x4, character timeout 0xC, transmit empty 0x2, modem status 0x0.
- R4: When several enabled causes are pending, the code shown follows this order, most urgent first: line error, receive data, character timeout, transmit empty, modem status.
- R5: `ier_en` bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line error and bit 3 enables modem status. A disabled cause is neither shown nor drives `irq`, but a held cause keeps its state and appears once it is enabled.
- R6: A pulse on any bit of `err_evt` (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) holds the line-error cause from the next cycle. A cycle with `lsr_read` high releases it, unless a new error arrives in that same cycle.
- R7: A `thr_went_empty` pulse holds the transmit-empty cause (TXE_OWED). Either of two events releases it: `thr_write`, or `ident_read` in a cycle where `ident[3:0]` shows 0x2. A read that shows any other code leaves it held. If an empty event and a release arrive in the same cycle, the cause stays held.
- R8: `irq` is high exactly when `mcr_out2` is high and at least one enabled cause is pending.
- R9: `ident[7:6]` reads 11 while `fifo_mode` is high and 00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_en | input | 4 | Per-cause enables (see R5) |
| err_evt | input | 4 | Line error pulses: overrun, parity, framing, break |
| rx_at_trigger | input | 1 | Receive FIFO at or above trigger level |
| rx_char_timeout | input | 1 | Receive character timeout active |
| thr_went_empty | input | 1 | Pulse: transmit holding register became empty |
| thr_write | input | 1 | Pulse: write to transmit holding register |
| ident_read | input | 1 | Pulse: read of the identification byte |
| lsr_read | input | 1 | Pulse: read of the line status register |
| modem_delta | input | 1 | Modem status change pending |
| fifo_mode | input | 1 | FIFOs enabled |
| mcr_out2 | input | 1 | Master interrupt enable from modem control |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A transmit-empty machine stuck in TXE_OWED shows up at the ports one cycle after an acknowledging read: `ident` still holds 0x2 instead of falling to 0x1 or to a lower cause. A machine stuck in TXE_QUIET shows 0x1 in the cycle after an empty pulse. A held line error that fails to release after `lsr_read` keeps 0x6 on `ident` and hides the receive-data code in the very next cycle. A wrong priority choice appears in the same cycle that two causes overlap. Every held-state fault is therefore visible within one clock of the event that should have changed it.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;

    localparam int SRC_EN_W  = 4;
    localparam int LERR_W    = 4;
    localparam int IDENT_W   = 8;

    localparam int EN_RX  = 0;
    localparam int EN_THR = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MS  = 3;

    typedef enum logic [3:0] {
        CODE_MODEM  = 4'h0,
        CODE_NONE   = 4'h1,
        CODE_THRE   = 4'h2,
        CODE_RXDATA = 4'h4,
        CODE_LINE   = 4'h6,
        CODE_CHARTO = 4'hC
    } int_code_e;

    typedef enum logic [0:0] {
        TXE_QUIET = 1'b0,
        TXE_OWED  = 1'b1
    } txe_state_e;

endpackage

// File: rtl/uart_lerr_hold.sv
module uart_lerr_hold #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_evt,
    input  logic             release_rd,
    output logic             pending
);

    logic [ERR_W-1:0] held_q;

    genvar gi;
    generate
        for (gi = 0; gi < ERR_W; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    held_q[gi] <= 1'b0;
                else if (err_evt[gi])
                    held_q[gi] <= 1'b1;
                else if (release_rd)
                    held_q[gi] <= 1'b0;
            end
        end
    endgenerate

    assign pending = |held_q;

endmodule

// File: rtl/uart_txe_fsm.sv
module uart_txe_fsm
    import uart_int_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty_evt,
    input  logic holding_wr,
    input  logic ack_read,
    output logic owed
);

    txe_state_e state_q, state_d;
    logic       ack;

    assign ack = holding_wr | ack_read;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TXE_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_QUIET: if (empty_evt) state_d = TXE_OWED;
            TXE_OWED:  if (ack && !empty_evt) state_d = TXE_QUIET;
            default:   state_d = TXE_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TXE_OWED: owed = 1'b1;
            default:  owed = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_int_prio.sv
module uart_int_prio
    import uart_int_pkg::*;
#(
    parameter int EN_W = SRC_EN_W,
    parameter int ID_W = IDENT_W
) (
    input  logic            ls_pend,
    input  logic            rx_data,
    input  logic            rx_to,
    input  logic            txe_pend,
    input  logic            ms_pend,
    input  logic [EN_W-1:0] en,
    input  logic            fifo_mode,
    output logic [ID_W-1:0] ident,
    output logic            any_pend,
    output logic            shows_thre
);

    localparam int HI_W  = 2;
    localparam int MID_W = ID_W - 4 - HI_W;

    int_code_e code;

    always_comb begin
        if (ls_pend && en[EN_LS])
            code = CODE_LINE;
        else if (rx_data && en[EN_RX])
            code = CODE_RXDATA;
        else if (rx_to && en[EN_RX])
            code = CODE_CHARTO;
        else if (txe_pend && en[EN_THR])
            code = CODE_THRE;
        else if (ms_pend && en[EN_MS])
            code = CODE_MODEM;
        else
            code = CODE_NONE;
    end

    assign any_pend   = (code != CODE_NONE);
    assign shows_thre = (code == CODE_THRE);
    assign ident      = {{HI_W{fifo_mode}}, {MID_W{1'b0}}, code};

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uart_int_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_EN_W-1:0] ier_en,
    input  logic [LERR_W-1:0]   err_evt,
    input  logic                rx_at_trigger,
    input  logic                rx_char_timeout,
    input  logic                thr_went_empty,
    input  logic                thr_write,
    input  logic                ident_read,
    input  logic                lsr_read,
    input  logic                modem_delta,
    input  logic                fifo_mode,
    input  logic                mcr_out2,
    output logic [IDENT_W-1:0]  ident,
    output logic                irq
);

    logic ls_pend;
    logic txe_owed;
    logic any_pend;
    logic shows_thre;

    uart_lerr_hold #(.ERR_W(LERR_W)) u_lerr (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_evt    (err_evt),
        .release_rd (lsr_read),
        .pending    (ls_pend)
    );

    uart_txe_fsm u_txe (
        .clk        (clk),
        .rst_n      (rst_n),
        .empty_evt  (thr_went_empty),
        .holding_wr (thr_write),
        .ack_read   (ident_read & shows_thre),
        .owed       (txe_owed)
    );

    uart_int_prio #(.EN_W(SRC_EN_W), .ID_W(IDENT_W)) u_prio (
        .ls_pend    (ls_pend),
        .rx_data    (rx_at_trigger),
        .rx_to      (rx_char_timeout),
        .txe_pend   (txe_owed),
        .ms_pend    (modem_delta),
        .en         (ier_en),
        .fifo_mode  (fifo_mode),
        .ident      (ident),
        .any_pend   (any_pend),
        .shows_thre (shows_thre)
    );

    assign irq = mcr_out2 & any_pend;

endmodule

// File: rtl/uart_int_ident_chk.sv
module uart_int_ident_chk
    import uart_int_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [SRC_EN_W-1:0] ier_en,
    input logic [LERR_W-1:0]   err_evt,
    input logic                rx_at_trigger,
    input logic                thr_went_empty,
    input logic                ident_read,
    input logic                fifo_mode,
    input logic                mcr_out2,
    input logic [IDENT_W-1:0]  ident,
    input logic                irq
);

    // R8
    irq_means_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!ident[0] && mcr_out2));

    // R2
    mid_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ident[5:4] == 2'b00);

    // R9
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ident[7:6] == {2{fifo_mode}});

    // R6
    line_err_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_evt != '0) && ier_en[EN_LS]) |=> (ident[3:0] == 4'h6 || !ier_en[EN_LS]));

    // R7
    thre_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_read && ident[3:0] == 4'h2 && !thr_went_empty) |=> (ident[3:0] != 4'h2));

    // R4
    rx_over_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_at_trigger && ier_en[EN_RX]) |-> (ident[3:0] == 4'h4 || ident[3:0] == 4'h6));

endmodule

bind uart_int_ident uart_int_ident_chk u_chk (.*);

// File: tb/sim_uart_int_ident.sv
`timescale 1ns/1ps
module sim_uart_int_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ier_en = 4'h0;
    logic [3:0] err_evt = 4'h0;
    logic       rx_at_trigger = 1'b0;
    logic       rx_char_timeout = 1'b0;
    logic       thr_went_empty = 1'b0;
    logic       thr_write = 1'b0;
    logic       ident_read = 1'b0;
    logic       lsr_read = 1'b0;
    logic       modem_delta = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       mcr_out2 = 1'b0;
    logic [7:0] ident;
    logic       irq;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    uart_int_ident u0 (.*);

    typedef struct packed {
        logic [3:0] en;
        logic       trig;
        logic       tmo;
        logic       mdm;
        logic       fifo;
        logic       out2;
        logic [7:0] exp_id;
        logic       exp_irq;
    } vec_t;

    // level-source vectors: R3, R4, R5, R8, R9
    localparam vec_t VECS [10] = '{
        '{4'hF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC4, 1'b1},
        '{4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0C, 1'b1},
        '{4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h04, 1'b1},
        '{4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1},
        '{4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0C, 1'b1},
        '{4'hE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1},
        '{4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0},
        '{4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
        '{4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC1, 1'b0},
        '{4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0}
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got {irq,ident}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_err(input logic [3:0] e);
        err_evt = e; step(); err_evt = 4'h0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        step();
        // R1: reset state
        check("R1", {irq, ident}, {1'b0, 8'h01});
        rst_n = 1'b1;
        step();
        ier_en = 4'hF; mcr_out2 = 1'b1;
        step();
        check("R1", {irq, ident}, {1'b0, 8'h01});

        // table walk: R2 R3 R4 R5 R8 R9
        for (int i = 0; i < 10; i++) begin
            ier_en = VECS[i].en; rx_at_trigger = VECS[i].trig;
            rx_char_timeout = VECS[i].tmo; modem_delta = VECS[i].mdm;
            fifo_mode = VECS[i].fifo; mcr_out2 = VECS[i].out2;
            step();
            check("R3/R4/R5/R8/R9 table", {irq, ident}, {VECS[i].exp_irq, VECS[i].exp_id});
        end
        ier_en = 4'hF; mcr_out2 = 1'b1; fifo_mode = 1'b0;

        // R6: line error outranks receive data, held until lsr_read
        rx_at_trigger = 1'b1;
        pulse_err(4'b0010);
        check("R6 line error held", {irq, ident}, {1'b1, 8'h06});
        step();
        check("R4 line over rx", {irq, ident}, {1'b1, 8'h06});
        lsr_read = 1'b1; step(); lsr_read = 1'b0;
        check("R6 released by lsr_read", {irq, ident}, {1'b1, 8'h04});
        rx_at_trigger = 1'b0;

        // R5: disabled line error stays held, appears on enable
        ier_en = 4'hB;
        pulse_err(4'b1000);
        check("R5 disabled line err hidden", {irq, ident}, {1'b0, 8'h01});
        ier_en = 4'hF;
        step();
        check("R5 held err shown on enable", {irq, ident}, {1'b1, 8'h06});
        lsr_read = 1'b1; err_evt = 4'b0001; step();
        lsr_read = 1'b0; err_evt = 4'h0;
        check("R6 new error wins over release", {irq, ident}, {1'b1, 8'h06});
        lsr_read = 1'b1; step(); lsr_read = 1'b0;
        check("R6 release", {irq, ident}, {1'b0, 8'h01});

        // R7: transmit empty, acked by read showing 0x2
        thr_went_empty = 1'b1; step(); thr_went_empty = 1'b0;
        check("R7 owed", {irq, ident}, {1'b1, 8'h02});
        ident_read = 1'b1; step(); ident_read = 1'b0;
        check("R7 read acks", {irq, ident}, {1'b0, 8'h01});

        // R7: ack by holding write
        thr_went_empty = 1'b1; step(); thr_went_empty = 1'b0;
        thr_write = 1'b1; step(); thr_write = 1'b0;
        check("R7 write acks", {irq, ident}, {1'b0, 8'h01});

        // R7: read showing another code leaves it held
        thr_went_empty = 1'b1; rx_at_trigger = 1'b1; step(); thr_went_empty = 1'b0;
        check("R4 rx over thre", {irq, ident}, {1'b1, 8'h04});
        ident_read = 1'b1; step(); ident_read = 1'b0;
        rx_at_trigger = 1'b0; step();
        check("R7 other-code read keeps owed", {irq, ident}, {1'b1, 8'h02});

        // R4: transmit empty over modem
        modem_delta = 1'b1; step();
        check("R4 thre over modem", {irq, ident}, {1'b1, 8'h02});
        thr_write = 1'b1; step(); thr_write = 1'b0;
        check("R3 modem code", {irq, ident}, {1'b1, 8'h00});
        modem_delta = 1'b0;

        // R7: event and ack same cycle -> stays owed
        thr_went_empty = 1'b1; step();
        thr_write = 1'b1; step(); thr_went_empty = 1'b0; thr_write = 1'b0;
        check("R7 event wins", {irq, ident}, {1'b1, 8'h02});

        // R5 + R7: disabled thre not acked by read, shows on enable
        ier_en = 4'hD; step();
        check("R5 thre hidden", {irq, ident}, {1'b0, 8'h01});
        ident_read = 1'b1; step(); ident_read = 1'b0;
        ier_en = 4'hF; step();
        check("R7 hidden read no ack", {irq, ident}, {1'b1, 8'h02});

        // R1: reset mid-run clears held causes
        err_evt = 4'b0100; step(); err_evt = 4'h0;
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        check("R1 reset clears held", {irq, ident}, {1'b0, 8'h01});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule